// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block sits on the bus side of an x16 parallel NOR flash and interprets the stream of word-addressed write cycles. These writes use the classic two-cycle unlock command set. The block tracks the operating mode: normal array reads, identification reads, query-table reads, or unlock-bypass. It also walks the multi-cycle prefixes for programming and erasing. When a complete program, sector-erase or chip-erase sequence is seen, it sends one single-cycle request to an external program/erase engine. While that engine is busy, it forwards suspend and resume commands.

Reads are combinational. The block chooses between the array data, two fixed identification words, and the word returned by an external query-table port. The array storage, the table contents and all erase timing are outside the block. The program rule that bits can only be cleared is applied here: the engine receives the AND of the old word and the new word, and the environment supplies the old word for the addressed location.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset the block is in array-read mode (read data equals `arr_rdata`) and all request outputs are low.
- R2: An unlock is data low byte 0xAA at an address whose low 11 bits are 0x555, followed by 0x55 at low 11 bits 0x2AA; address bits above bit 10 are ignored, so 0x5555/0x2AAA also unlock. Only the low data byte is decoded as a command.
- R3: Unlock followed by 0x90 at 0x555 enters identification mode: a read at word 0 returns 0x00BF, at word 1 returns 0x236D, at any other word 0x0000; 0xF0 at any address returns to array-read.
- R4: 0x98 written at low-11-bit address 0x055 while idle enters query mode, where read data equals `cfi_rdata`; 0xF0 leaves query mode and restores the mode held before it, so identification mode survives a query visit.
- R5: Unlock, 0xA0 at 0x555, then one data write produces `prog_req` for exactly one cycle on the cycle after the data write, with `req_addr` the data-write address and `req_data` the AND of `old_word` and the written data.
- R6: Unlock, 0x80 at 0x555 and a second unlock, then 0x30 at any address gives `sect_erase_req` carrying that address, or 0x10 at 0x555 gives `chip_erase_req`; `req_data` carries the written word.
- R7: Unlock then 0x20 at 0x555 enters unlock-bypass, where 0xA0 at any address followed by a data write is a full program; writing 0x00 leaves bypass, after which a bare 0xA0 plus data issues nothing and leaves the array unchanged.
- R8: Any write that does not match the next step of a sequence drops the sequence with no request; the current read mode is kept and a later complete sequence works normally.
- R9: While `busy` is high, only 0xB0 (giving `suspend_req`) and 0x30 (giving `resume_req`) have an effect, each at any address; all other writes are ignored and no program or erase request is issued.
- R10: At most one request output is high in any cycle, and every request follows a write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe, one cycle per bus write |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 16 | Write data; the low byte holds commands |
| old_word | input | 16 | Current array content at `wr_addr` |
| busy | input | 1 | Program/erase engine is operating |
| rd_addr | input | AW | Word address of the read |
| arr_rdata | input | 16 | Array word at `rd_addr` |
| cfi_rdata | input | 16 | Query-table word at `rd_addr` |
| rd_data | output | 16 | Read data after mode selection |
| prog_req | output | 1 | One-cycle program request |
| sect_erase_req | output | 1 | One-cycle sector-erase request |
| chip_erase_req | output | 1 | One-cycle chip-erase request |
| suspend_req | output | 1 | One-cycle erase-suspend request |
| resume_req | output | 1 | One-cycle erase-resume request |
| req_addr | output | AW | Address carried with a request |
| req_data | output | 16 | Data carried with a request |

## Verification
The bench programs the same word twice and expects the AND of the two values. A decoder that passes the raw new data would leave 0xA5 where 0x05 belongs. It enters the query table from identification mode and exits again, so a design that drops back to array reads on exit returns array data instead of 0x00BF. It sends broken prefixes: a program command at the wrong address, and a second erase unlock with the wrong address. A decoder that does not abort would then issue a spurious program or erase. It also checks the bypass exit and command writes made while busy; a design that keeps bypass open, or obeys commands during busy, produces requests that the scoreboard never expected.

// File: rtl/nor_cmd_pkg.sv
// Shared command codes, address patterns and state types for the NOR
// flash command decoder. Assumes commands sit in the low data byte.
package nor_cmd_pkg;
    localparam int MATCH_W = 11;

    localparam logic [7:0] C_UNL_A    = 8'hAA;
    localparam logic [7:0] C_UNL_B    = 8'h55;
    localparam logic [7:0] C_PROG     = 8'hA0;
    localparam logic [7:0] C_ERASE    = 8'h80;
    localparam logic [7:0] C_IDENT    = 8'h90;
    localparam logic [7:0] C_QUERY    = 8'h98;
    localparam logic [7:0] C_EXIT     = 8'hF0;
    localparam logic [7:0] C_BYP      = 8'h20;
    localparam logic [7:0] C_BYP_EXIT = 8'h00;
    localparam logic [7:0] C_SECT     = 8'h30;
    localparam logic [7:0] C_CHIP     = 8'h10;
    localparam logic [7:0] C_SUSP     = 8'hB0;
    localparam logic [7:0] C_RES      = 8'h30;

    localparam logic [MATCH_W-1:0] A_UNL_A = 11'h555;
    localparam logic [MATCH_W-1:0] A_UNL_B = 11'h2AA;
    localparam logic [MATCH_W-1:0] A_QUERY = 11'h055;

    typedef enum logic [1:0] {
        BASE_ARRAY,
        BASE_IDENT,
        BASE_BYPASS
    } base_mode_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_CMD,
        SQ_PROG,
        SQ_ERA1,
        SQ_ERA2,
        SQ_ERA3,
        SQ_BPROG
    } seq_t;

    typedef enum logic [2:0] {
        RQ_NONE = 3'd0,
        RQ_PROG = 3'd1,
        RQ_SECT = 3'd2,
        RQ_CHIP = 3'd3,
        RQ_SUSP = 3'd4,
        RQ_RES  = 3'd5
    } req_kind_t;

    localparam int N_REQ = 5;
endpackage

// File: rtl/nor_addr_match.sv
// Partial address comparator: flags the three command addresses using
// only the low MATCH_W bits. Assumes the caller slices the address.
module nor_addr_match
    import nor_cmd_pkg::*;
(
    input  logic [MATCH_W-1:0] addr_lo,
    output logic               hit_unl_a,
    output logic               hit_unl_b,
    output logic               hit_query
);
    // Compare the sliced address against each fixed command address.
    assign hit_unl_a = (addr_lo == A_UNL_A);
    assign hit_unl_b = (addr_lo == A_UNL_B);
    assign hit_query = (addr_lo == A_QUERY);
endmodule

// File: rtl/nor_seq_fsm.sv
// Command sequencer: walks unlock prefixes, tracks the read mode and the
// query overlay, and produces a request kind for the current write.
// Assumes one write per wr_en cycle and a command in the low data byte.
module nor_seq_fsm
    import nor_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] cmd,
    input  logic       hit_unl_a,
    input  logic       hit_unl_b,
    input  logic       hit_query,
    input  logic       busy,
    output base_mode_t base_q,
    output logic       query_q,
    output req_kind_t  req_next
);
    seq_t       seq_q, seq_n;
    base_mode_t base_n;
    logic       query_n;

    // Next-state decode of the write stream.
    always_comb begin
        seq_n    = seq_q;
        base_n   = base_q;
        query_n  = query_q;
        req_next = RQ_NONE;
        if (wr_en) begin
            if (busy) begin
                if (cmd == C_SUSP)     req_next = RQ_SUSP;
                else if (cmd == C_RES) req_next = RQ_RES;
            end else if (query_q) begin
                seq_n = SQ_IDLE;
                if (cmd == C_EXIT) query_n = 1'b0;
            end else if (base_q == BASE_BYPASS) begin
                if (seq_q == SQ_BPROG) begin
                    req_next = RQ_PROG;
                    seq_n    = SQ_IDLE;
                end else if (cmd == C_PROG) begin
                    seq_n = SQ_BPROG;
                end else if (cmd == C_BYP_EXIT) begin
                    base_n = BASE_ARRAY;
                    seq_n  = SQ_IDLE;
                end
            end else begin
                seq_n = SQ_IDLE;
                unique case (seq_q)
                    SQ_IDLE: begin
                        if (cmd == C_UNL_A && hit_unl_a)       seq_n   = SQ_UNL1;
                        else if (cmd == C_QUERY && hit_query)  query_n = 1'b1;
                        else if (cmd == C_EXIT)                base_n  = BASE_ARRAY;
                    end
                    SQ_UNL1: if (cmd == C_UNL_B && hit_unl_b) seq_n = SQ_CMD;
                    SQ_CMD: begin
                        if (hit_unl_a) begin
                            if (cmd == C_PROG)       seq_n  = SQ_PROG;
                            else if (cmd == C_ERASE) seq_n  = SQ_ERA1;
                            else if (cmd == C_IDENT) base_n = BASE_IDENT;
                            else if (cmd == C_BYP)   base_n = BASE_BYPASS;
                        end
                    end
                    SQ_PROG: req_next = RQ_PROG;
                    SQ_ERA1: if (cmd == C_UNL_A && hit_unl_a) seq_n = SQ_ERA2;
                    SQ_ERA2: if (cmd == C_UNL_B && hit_unl_b) seq_n = SQ_ERA3;
                    SQ_ERA3: begin
                        if (cmd == C_SECT)                  req_next = RQ_SECT;
                        else if (cmd == C_CHIP && hit_unl_a) req_next = RQ_CHIP;
                    end
                    default: seq_n = SQ_IDLE;
                endcase
            end
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q   <= SQ_IDLE;
            base_q  <= BASE_ARRAY;
            query_q <= 1'b0;
        end else begin
            seq_q   <= seq_n;
            base_q  <= base_n;
            query_q <= query_n;
        end
    end
endmodule

// File: rtl/nor_req_stage.sv
// Request output stage: registers the request kind with its address and
// data, applying the bit-clearing rule to programs. Assumes old_word is
// the array word at wr_addr during the write cycle.
module nor_req_stage
    import nor_cmd_pkg::*;
#(
    parameter int AW = 22,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  req_kind_t     req_next,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] old_word,
    output logic [N_REQ-1:0] req_vec,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    req_kind_t kind_q;

    // Capture the request and its payload for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= RQ_NONE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            kind_q <= req_next;
            if (req_next != RQ_NONE) begin
                addr_q <= wr_addr;
                data_q <= (req_next == RQ_PROG) ? (old_word & wr_data) : wr_data;
            end
        end
    end

    // One strobe line per request kind.
    for (genvar k = 0; k < N_REQ; k++) begin : g_req
        assign req_vec[k] = (kind_q == req_kind_t'(k + 1));
    end
endmodule

// File: rtl/nor_read_mux.sv
// Read source selector: query table, identification words or array,
// chosen by the current mode. Purely combinational.
module nor_read_mux
    import nor_cmd_pkg::*;
#(
    parameter int          AW     = 22,
    parameter int          DW     = 16,
    parameter logic [DW-1:0] MFR_ID = 16'h00BF,
    parameter logic [DW-1:0] DEV_ID = 16'h236D
) (
    input  base_mode_t    base_mode,
    input  logic          query_on,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_rdata,
    input  logic [DW-1:0] cfi_rdata,
    output logic [DW-1:0] rd_data
);
    // Pick the read source for the active mode.
    always_comb begin
        if (query_on) begin
            rd_data = cfi_rdata;
        end else if (base_mode == BASE_IDENT) begin
            if (rd_addr == AW'(0))      rd_data = MFR_ID;
            else if (rd_addr == AW'(1)) rd_data = DEV_ID;
            else                        rd_data = '0;
        end else begin
            rd_data = arr_rdata;
        end
    end
endmodule

// File: rtl/nor_cmd_decoder.sv
// Top of the NOR flash command decoder: partial address match, command
// sequencer, request register and read selector. Assumes AW >= 11 and
// an external engine that asserts busy while programming or erasing.
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int AW = 22,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] old_word,
    input  logic          busy,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_rdata,
    input  logic [DW-1:0] cfi_rdata,
    output logic [DW-1:0] rd_data,
    output logic          prog_req,
    output logic          sect_erase_req,
    output logic          chip_erase_req,
    output logic          suspend_req,
    output logic          resume_req,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_data
);
    localparam int CMD_W = 8;

    logic             hit_unl_a, hit_unl_b, hit_query;
    base_mode_t       base_mode;
    logic             query_on;
    req_kind_t        req_next;
    logic [N_REQ-1:0] req_vec;

    nor_addr_match u_match (
        .addr_lo   (wr_addr[MATCH_W-1:0]),
        .hit_unl_a (hit_unl_a),
        .hit_unl_b (hit_unl_b),
        .hit_query (hit_query)
    );

    nor_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .cmd       (wr_data[CMD_W-1:0]),
        .hit_unl_a (hit_unl_a),
        .hit_unl_b (hit_unl_b),
        .hit_query (hit_query),
        .busy      (busy),
        .base_q    (base_mode),
        .query_q   (query_on),
        .req_next  (req_next)
    );

    nor_req_stage #(.AW(AW), .DW(DW)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_next (req_next),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .old_word (old_word),
        .req_vec  (req_vec),
        .addr_q   (req_addr),
        .data_q   (req_data)
    );

    nor_read_mux #(.AW(AW), .DW(DW)) u_rd (
        .base_mode (base_mode),
        .query_on  (query_on),
        .rd_addr   (rd_addr),
        .arr_rdata (arr_rdata),
        .cfi_rdata (cfi_rdata),
        .rd_data   (rd_data)
    );

    assign prog_req       = req_vec[int'(RQ_PROG) - 1];
    assign sect_erase_req = req_vec[int'(RQ_SECT) - 1];
    assign chip_erase_req = req_vec[int'(RQ_CHIP) - 1];
    assign suspend_req    = req_vec[int'(RQ_SUSP) - 1];
    assign resume_req     = req_vec[int'(RQ_RES) - 1];
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
// Property checker for the command decoder, attached by bind below.
module nor_cmd_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic busy,
    input logic prog_req,
    input logic sect_erase_req,
    input logic chip_erase_req,
    input logic suspend_req,
    input logic resume_req
);
    logic any_req, work_req, ctl_req;
    assign work_req = prog_req | sect_erase_req | chip_erase_req;
    assign ctl_req  = suspend_req | resume_req;
    assign any_req  = work_req | ctl_req;

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !any_req);

    a_r10_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, sect_erase_req, chip_erase_req, suspend_req, resume_req}));

    a_r10_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> $past(wr_en));

    a_r5_prog_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    a_r9_busy_blocks_work: assert property (@(posedge clk) disable iff (!rst_n)
        work_req |-> !$past(busy));

    a_r9_ctl_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_req |-> $past(busy));
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .busy           (busy),
    .prog_req       (prog_req),
    .sect_erase_req (sect_erase_req),
    .chip_erase_req (chip_erase_req),
    .suspend_req    (suspend_req),
    .resume_req     (resume_req)
);

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int WATCHDOG_CYCLES = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] old_word = '0;
    logic          busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_rdata = '0;
    logic [DW-1:0] cfi_rdata = '0;
    logic [DW-1:0] rd_data;
    logic          prog_req, sect_erase_req, chip_erase_req, suspend_req, resume_req;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;

    nor_cmd_decoder #(.AW(AW), .DW(DW)) u_nor_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .old_word(old_word), .busy(busy),
        .rd_addr(rd_addr), .arr_rdata(arr_rdata), .cfi_rdata(cfi_rdata),
        .rd_data(rd_data), .prog_req(prog_req), .sect_erase_req(sect_erase_req),
        .chip_erase_req(chip_erase_req), .suspend_req(suspend_req),
        .resume_req(resume_req), .req_addr(req_addr), .req_data(req_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Bench-side array model and scoreboard.
    logic [DW-1:0] mem [int];
    typedef struct packed {
        logic [2:0]    kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;

    localparam logic [2:0] K_PROG = 3'd1, K_SECT = 3'd2, K_CHIP = 3'd3,
                           K_SUSP = 3'd4, K_RES = 3'd5;

    function automatic logic [DW-1:0] mem_get(input logic [AW-1:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 16'hFFFF;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_req(input logic [2:0] k, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input string tag);
        exp_q.push_back('{kind: k, addr: a, data: d});
        tag_q.push_back(tag);
    endtask

    // Monitor: pops expected requests as the design produces them.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [2:0] k;
            k = prog_req ? K_PROG : sect_erase_req ? K_SECT : chip_erase_req ? K_CHIP :
                suspend_req ? K_SUSP : resume_req ? K_RES : 3'd0;
            if (k != 3'd0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected request", {29'd0, k}, 32'd0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(k == e.kind, {t, " kind"}, {29'd0, k}, {29'd0, e.kind});
                    check(req_addr == e.addr, {t, " addr"}, 32'(req_addr), 32'(e.addr));
                    check(req_data == e.data, {t, " data"}, 32'(req_data), 32'(e.data));
                end
                if (k == K_PROG) mem[int'(req_addr)] = req_data;
                if (k == K_CHIP) mem.delete();
            end
        end
    end

    // Driver: one write cycle then one idle cycle, starting at a falling edge.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_addr  = a;
        wr_data  = d;
        old_word = mem_get(a);
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic unlock(input bit alias_hi);
        wr(alias_hi ? AW'(22'h5555) : AW'(22'h555), 16'h00AA);
        wr(alias_hi ? AW'(22'h2AAA) : AW'(22'h2AA), 16'h0055);
    endtask

    task automatic program_word(input logic [AW-1:0] a, input logic [DW-1:0] d,
                                input string tag);
        expect_req(K_PROG, a, mem_get(a) & d, tag);
        unlock(1'b0);
        wr(AW'(22'h555), 16'h00A0);
        wr(a, d);
    endtask

    task automatic erase_prefix();
        unlock(1'b0);
        wr(AW'(22'h555), 16'h0080);
        unlock(1'b0);
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                          input string tag);
        rd_addr   = a;
        arr_rdata = mem_get(a);
        cfi_rdata = 16'hC000 ^ a[15:0];
        #1;
        check(rd_data == exp, tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state reads the array with no requests pending.
        rd_chk(AW'(5), 16'hFFFF, "R1 array read after reset");
        check(!(prog_req | sect_erase_req | chip_erase_req | suspend_req | resume_req),
              "R1 requests idle", 32'd0, 32'd0);

        // R5: bit-clearing program, twice on the same word.
        program_word(AW'(22'h100), 16'h0055, "R5 first program");
        rd_chk(AW'(22'h100), 16'h0055, "R5 word after first program");
        program_word(AW'(22'h100), 16'h00A5, "R5 second program AND");
        rd_chk(AW'(22'h100), 16'h0005, "R5 word after second program");

        // R2/R3: alias unlock enters identification mode.
        unlock(1'b1);
        wr(AW'(22'h5555), 16'h0090);
        rd_chk(AW'(0), 16'h00BF, "R2 R3 manufacturer word");
        rd_chk(AW'(1), 16'h236D, "R3 device word");
        rd_chk(AW'(2), 16'h0000, "R3 other word");

        // R4: query from identification mode, exit restores identification.
        wr(AW'(22'h55), 16'h0098);
        rd_chk(AW'(22'h10), 16'hC010, "R4 query table data");
        wr(AW'(0), 16'h00F0);
        rd_chk(AW'(0), 16'h00BF, "R4 identification kept after query exit");
        wr(AW'(0), 16'h00F0);
        rd_chk(AW'(22'h100), 16'h0005, "R3 exit back to array");

        // R6: sector erase at an arbitrary address, then chip erase.
        expect_req(K_SECT, AW'(22'h8000), 16'h0030, "R6 sector erase");
        erase_prefix();
        wr(AW'(22'h8000), 16'h0030);
        expect_req(K_CHIP, AW'(22'h555), 16'h0010, "R6 chip erase");
        erase_prefix();
        wr(AW'(22'h555), 16'h0010);
        rd_chk(AW'(22'h100), 16'hFFFF, "R6 array blank after chip erase");

        // R9: only suspend/resume act while busy.
        busy = 1'b1;
        unlock(1'b0);
        wr(AW'(22'h555), 16'h00A0);
        wr(AW'(22'h200), 16'h0000);
        expect_req(K_SUSP, AW'(0), 16'h00B0, "R9 suspend");
        wr(AW'(0), 16'h00B0);
        expect_req(K_RES, AW'(22'h40), 16'h0030, "R9 resume");
        wr(AW'(22'h40), 16'h0030);
        busy = 1'b0;
        rd_chk(AW'(22'h200), 16'hFFFF, "R9 word untouched while busy");

        // R7: bypass programs with no unlock, then exit.
        unlock(1'b0);
        wr(AW'(22'h555), 16'h0020);
        expect_req(K_PROG, AW'(22'h10), 16'h1234, "R7 bypass program one");
        wr(AW'(22'h777), 16'h00A0);
        wr(AW'(22'h10), 16'h1234);
        expect_req(K_PROG, AW'(22'h11), 16'h00F0, "R7 bypass program two");
        wr(AW'(22'h3), 16'h00A0);
        wr(AW'(22'h11), 16'h00F0);
        wr(AW'(0), 16'h0000);
        wr(AW'(22'h555), 16'h00A0);
        wr(AW'(22'h12), 16'h0F0F);
        rd_chk(AW'(22'h12), 16'hFFFF, "R7 bare program ignored after exit");
        rd_chk(AW'(22'h10), 16'h1234, "R7 bypass word stored");

        // R8: broken sequences abort with no request.
        unlock(1'b0);
        wr(AW'(22'h123), 16'h00A0);
        wr(AW'(22'h20), 16'h0000);
        rd_chk(AW'(22'h20), 16'hFFFF, "R8 wrong program address aborts");
        unlock(1'b0);
        wr(AW'(22'h555), 16'h0080);
        wr(AW'(22'h555), 16'h00AA);
        wr(AW'(22'h2AB), 16'h0055);
        wr(AW'(22'h40), 16'h0030);
        program_word(AW'(22'h20), 16'h4321, "R8 full sequence after abort");
        rd_chk(AW'(22'h20), 16'h4321, "R8 program after abort stored");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all expected requests seen",
              32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule